// File: doc/BRIEF.md
# Shift and Rotate Unit with Single Right-Funnel Datapath

This block carries out the seven classic integer shift and rotate operations (rotate left and right, rotate left and right through carry, logical shift left and right, arithmetic shift right) on byte, word and doubleword operands. Every operation is turned into a right shift. A setup stage builds a double-width shifter input and one right-shift amount. A two-stage funnel shifter then does the shift, with a coarse step in multiples of four bits followed by a fine step of zero to three bits. The low operand-width bits of its output are the result.

A small controller sequences each request through three states. ST_IDLE waits for `start` and latches the request. ST_SETUP registers the prepared shifter input and amount. ST_SHIFT registers the masked result and raises `done`. The transitions are: ST_IDLE to ST_SETUP on `start`; ST_SETUP to ST_SHIFT always; ST_SHIFT to ST_IDLE always. `busy` is high outside ST_IDLE. `start` is accepted only in ST_IDLE. For the through-carry rotates, only counts from 1 up to the operand width are supported. Larger counts give an unspecified result. Flags other than the result are not produced.

Top module: `shf_unit`

## Requirements
- R1: With `op` 000 (rotate left) or 001 (rotate right), the operand is rotated by the masked count modulo the operand width.
- R2: With `op` 101 (logical right), zeros enter from the top, and a masked count of at least the width gives 0.
- R3: With `op` 100 (logical left), zeros enter from the bottom, and a masked count of at least the width gives 0.
- R4: With `op` 111 (arithmetic right), copies of the operand's top bit enter from the top, and a masked count of width-1 or more gives all copies of that bit.
- R5: With `op` 011, the width+1 bit value {carry_in, operand} is rotated right by the count (1..width), and the low width bits are returned.
- R6: With `op` 010, the width+1 bit value {carry_in, operand} is rotated left by the count (1..width), and the low width bits are returned.
- R7: Only `count[4:0]` is used; `count[7:5]` has no effect on the result.
- R8: A masked count of 0 returns the operand, masked to the width, for every operation.
- R9: `size` 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. Operand bits above the width are ignored, and result bits above the width are 0.
- R10: After reset, `done`, `busy` and `result` are 0. `start` sampled in ST_IDLE gives a one-cycle `done` pulse two clock edges later, and `result` is valid while `done` is high and holds until the next request completes.
- R11: `start` while `busy` is ignored. The running request completes with its own inputs, and no further `done` follows.
- R12: `op` 110 behaves exactly as logical left (100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted in ST_IDLE |
| op | input | 3 | Operation code (see R1 to R6 and R12) |
| size | input | 2 | Operand width code (see R9) |
| operand | input | 32 | Value to shift or rotate |
| carry_in | input | 1 | Carry bit used by the through-carry rotates |
| count | input | 8 | Raw shift count; only bits 4:0 are used |
| busy | output | 1 | High in ST_SETUP and ST_SHIFT |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Masked result, valid with `done` |

## Verification
The bench aims at counts at and beyond the operand width. There, a design with the wrong complement or clamp on the left shift or arithmetic shift would return garbage instead of zero or sign copies. It also hits the width+1 rotates at count equal to the width. There, misplacing the carry in the lower or upper half shows up as a bit slipped by one position. Narrow operands with junk in the upper bits would expose a funnel that lets those bits leak into the result. A start held high during a running request would reveal a design that restarts or relatches mid-flight.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        OP_ROL = 3'b000,
        OP_ROR = 3'b001,
        OP_RCL = 3'b010,
        OP_RCR = 3'b011,
        OP_SHL = 3'b100,
        OP_SHR = 3'b101,
        OP_SAL = 3'b110,
        OP_SAR = 3'b111
    } shf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2
    } shf_state_e;

    // Operand width in bits from the size code.
    function automatic logic [5:0] width_of(input logic [1:0] sz);
        case (sz)
            2'b00:   return 6'd8;
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/shf_setup.sv
module shf_setup
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int SH_W   = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [2:0]          op,
    input  logic [1:0]          size,
    input  logic [DATA_W-1:0]   x,
    input  logic                cf,
    input  logic [CNT_W-1:0]    cnt,
    output logic [2*DATA_W-1:0] pack,
    output logic [AMT_W-1:0]    amt,
    output logic [DATA_W-1:0]   mask
);

    logic [5:0]        w;
    logic [5:0]        n;
    logic [5:0]        kmod;
    logic [5:0]        amt6;
    logic [DATA_W-1:0] xm;
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
    logic              sign;

    always_comb begin
        w    = width_of(size);
        mask = (w == 6'd32) ? {DATA_W{1'b1}} : ((DATA_W'(1) << w) - DATA_W'(1));
        xm   = x & mask;
        sign = |(xm & ~(mask >> 1));
        n    = {{(6-SH_W){1'b0}}, cnt[SH_W-1:0]};
        kmod = n & (w - 6'd1);
        hi   = '0;
        lo   = xm;
        amt6 = '0;
        if (n != 6'd0) begin
            unique case (shf_op_e'(op))
                OP_ROR: begin
                    hi   = xm;
                    amt6 = kmod;
                end
                OP_ROL: begin
                    hi   = xm;
                    amt6 = (w - kmod) & (w - 6'd1);
                end
                OP_SHR: begin
                    amt6 = n;
                end
                OP_SAR: begin
                    hi   = sign ? mask : '0;
                    amt6 = (n >= w) ? (w - 6'd1) : n;
                end
                OP_SHL, OP_SAL: begin
                    lo = '0;
                    if (n < w) begin
                        hi   = xm;
                        amt6 = w - n;
                    end
                end
                OP_RCR: begin
                    hi   = ((xm << 1) | DATA_W'(cf)) & mask;
                    amt6 = n;
                end
                OP_RCL: begin
                    hi   = xm;
                    lo   = (xm >> 1) | (DATA_W'(cf) << (w - 6'd1));
                    amt6 = w - n;
                end
            endcase
        end
        pack = ({{DATA_W{1'b0}}, hi} << w) | {{DATA_W{1'b0}}, lo};
        amt  = amt6[AMT_W-1:0];
    end

endmodule

// File: rtl/shf_funnel.sv
module shf_funnel #(
    parameter int IN_W   = 64,
    parameter int OUT_W  = 32,
    parameter int AMT_W  = 5,
    parameter int FINE_W = 2,
    localparam int STEP     = 2 ** FINE_W,
    localparam int COARSE_N = 2 ** (AMT_W - FINE_W),
    localparam int MID_W    = OUT_W + STEP - 1
) (
    input  logic [IN_W-1:0]  din,
    input  logic [AMT_W-1:0] amt,
    output logic [OUT_W-1:0] dout
);

    logic [AMT_W-FINE_W-1:0] sel_c;
    logic [FINE_W-1:0]       sel_f;
    logic [MID_W-1:0]        mid;

    assign sel_c = amt[AMT_W-1:FINE_W];
    assign sel_f = amt[FINE_W-1:0];

    // Coarse stage: shift by a multiple of STEP.
    for (genvar i = 0; i < MID_W; i++) begin : g_coarse
        logic b;
        always_comb begin
            b = 1'b0;
            for (int c = 0; c < COARSE_N; c++) begin
                if (int'(sel_c) == c) b = din[i + STEP*c];
            end
        end
        assign mid[i] = b;
    end

    // Fine stage: shift by 0 .. STEP-1.
    for (genvar j = 0; j < OUT_W; j++) begin : g_fine
        logic b;
        always_comb begin
            b = 1'b0;
            for (int f = 0; f < STEP; f++) begin
                if (int'(sel_f) == f) b = mid[j + f];
            end
        end
        assign dout[j] = b;
    end

endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output shf_state_e state,
    output logic       load_in,
    output logic       load_setup,
    output logic       load_result,
    output logic       busy,
    output logic       done
);

    shf_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: state_nx = ST_SHIFT;
            ST_SHIFT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        load_in     = (state == ST_IDLE) && start;
        load_setup  = (state == ST_SETUP);
        load_result = (state == ST_SHIFT);
        busy        = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= load_result;
    end

    p_setup_to_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SETUP |=> state == ST_SHIFT);
    p_done_after_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SHIFT |=> done && state == ST_IDLE);
    p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |=> state != ST_SETUP);

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int SH_W   = 5,
    parameter int FINE_W = 2,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    shf_state_e          state;
    logic                load_in, load_setup, load_result;
    logic [2:0]          op_q;
    logic [1:0]          size_q;
    logic [DATA_W-1:0]   x_q;
    logic                cf_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [2*DATA_W-1:0] pack_d, pack_q;
    logic [AMT_W-1:0]    amt_d, amt_q;
    logic [DATA_W-1:0]   mask_d, mask_q;
    logic [DATA_W-1:0]   shifted;

    shf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .state       (state),
        .load_in     (load_in),
        .load_setup  (load_setup),
        .load_result (load_result),
        .busy        (busy),
        .done        (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            size_q <= '0;
            x_q    <= '0;
            cf_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (load_in) begin
            op_q   <= op;
            size_q <= size;
            x_q    <= operand;
            cf_q   <= carry_in;
            cnt_q  <= count;
        end
    end

    shf_setup #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_setup (
        .op   (op_q),
        .size (size_q),
        .x    (x_q),
        .cf   (cf_q),
        .cnt  (cnt_q),
        .pack (pack_d),
        .amt  (amt_d),
        .mask (mask_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pack_q <= '0;
            amt_q  <= '0;
            mask_q <= '0;
        end else if (load_setup) begin
            pack_q <= pack_d;
            amt_q  <= amt_d;
            mask_q <= mask_d;
        end
    end

    shf_funnel #(.IN_W(2*DATA_W), .OUT_W(DATA_W), .AMT_W(AMT_W), .FINE_W(FINE_W)) u_funnel (
        .din  (pack_q),
        .amt  (amt_q),
        .dout (shifted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           result <= '0;
        else if (load_result) result <= shifted & mask_q;
    end

    p_width_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result & ~mask_q) == '0);
    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && cnt_q[SH_W-1:0] == '0 |-> result == (x_q & mask_q));
    p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(x_q) && $stable(op_q) && $stable(cnt_q));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic [7:0]  count = '0;
    logic        busy, done;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    shf_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .operand(operand), .carry_in(carry_in), .count(count),
        .busy(busy), .done(done), .result(result)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, act=%0d cycles exp=<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R1";
            3'd2:       return "R6";
            3'd3:       return "R5";
            3'd4:       return "R3";
            3'd5:       return "R2";
            3'd6:       return "R12";
            default:    return "R4";
        endcase
    endfunction

    function automatic logic [31:0] ref_model(input logic [2:0] o, input logic [1:0] sz,
                                              input logic [31:0] x, input logic c_in,
                                              input logic [7:0] cnt);
        int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        logic [31:0] msk = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        logic [31:0] v = x & msk;
        logic c = c_in;
        logic t;
        int n = int'(cnt[4:0]);
        logic s = v[w-1];
        for (int i = 0; i < n; i++) begin
            case (o)
                3'd0: v = ((v << 1) | {31'd0, v[w-1]}) & msk;
                3'd1: v = (v >> 1) | ({31'd0, v[0]} << (w-1));
                3'd2: begin t = v[w-1]; v = ((v << 1) | {31'd0, c}) & msk; c = t; end
                3'd3: begin t = v[0]; v = (v >> 1) | ({31'd0, c} << (w-1)); c = t; end
                3'd4, 3'd6: v = (v << 1) & msk;
                3'd5: v = v >> 1;
                default: v = (v >> 1) | ({31'd0, s} << (w-1));
            endcase
        end
        return v;
    endfunction

    // Issue one request; returns the edges counted until done is seen.
    task automatic run_op(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] x,
                          input logic c, input logic [7:0] cnt,
                          output logic [31:0] res, output int lat);
        @(negedge clk);
        op = o; size = sz; operand = x; carry_in = c; count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        res = result;
    endtask

    task automatic do_check(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] x,
                            input logic c, input logic [7:0] cnt, input string tag);
        logic [31:0] res, exp;
        int lat;
        run_op(o, sz, x, c, cnt, res, lat);
        exp = ref_model(o, sz, x, c, cnt);
        check(res == exp, tag, res, exp);
        check(lat == 2, "R10 latency", 32'(lat), 32'd2);
    endtask

    initial begin
        logic [31:0] res, exp;
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);

        // R10: reset state
        #1;
        check(done == 1'b0 && busy == 1'b0, "R10 reset flags", {30'd0, busy, done}, 32'd0);
        check(result == 32'd0, "R10 reset result", result, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        do_check(3'd3, 2'd0, 32'h0000_000A, 1'b1, 8'd1, "R5 rcr byte");       // 0x85
        check(ref_model(3'd3, 2'd0, 32'h0A, 1'b1, 8'd1) == 32'h85, "R5 model", ref_model(3'd3, 2'd0, 32'h0A, 1'b1, 8'd1), 32'h85);
        do_check(3'd3, 2'd0, 32'h0000_00C3, 1'b0, 8'd8, "R5 rcr at width");
        do_check(3'd2, 2'd2, 32'h8000_0001, 1'b1, 8'd32, "R6 rcl at width");
        do_check(3'd4, 2'd2, 32'h0000_0001, 1'b0, 8'd5, "R3 shl dword");
        do_check(3'd4, 2'd0, 32'h0000_00FF, 1'b0, 8'd9, "R3 shl beyond width");
        do_check(3'd7, 2'd0, 32'h0000_0080, 1'b0, 8'd31, "R4 sar beyond width");
        do_check(3'd1, 2'd1, 32'h0000_8001, 1'b0, 8'd17, "R1 ror word mod width");
        do_check(3'd5, 2'd0, 32'hFFFF_FF80, 1'b0, 8'd7, "R9 shr junk upper bits");
        do_check(3'd0, 2'd3, 32'h1234_5678, 1'b0, 8'd4, "R9 size code 11 is 32 bits");
        do_check(3'd0, 2'd1, 32'hABCD_1234, 1'b1, 8'h20, "R7 R8 masked count zero");
        do_check(3'd6, 2'd1, 32'h0000_1234, 1'b0, 8'd3, "R12 op 110");

        // R11: start held high during a running request with other inputs
        @(negedge clk);
        op = 3'd1; size = 2'd2; operand = 32'h0000_00F0; carry_in = 1'b0; count = 8'd4; start = 1'b1;
        @(negedge clk);
        op = 3'd4; operand = 32'hFFFF_FFFF; count = 8'd1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        exp = 32'h0000_000F;
        check(done == 1'b1 && result == exp, "R11 busy start ignored", result, exp);
        begin
            int extra = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R11 no extra done", 32'(extra), 32'd0);
        end

        // Random sweep: every op, size, count
        for (int o = 0; o < 8; o++) begin
            for (int sz = 0; sz < 3; sz++) begin
                int w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
                for (int n = 0; n < 32; n++) begin
                    logic [7:0] raw;
                    if ((o == 2 || o == 3) && n > w) continue;
                    raw = {3'($urandom), 5'(n)};
                    do_check(3'(o), 2'(sz), $urandom, 1'($urandom), raw,
                             (n == 0) ? "R8" : (raw[7:5] != 3'd0) ? {req_of(3'(o)), " R7"} : req_of(3'(o)));
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule